// File: doc/BRIEF.md
# Panel self-refresh entry and exit sequencer

This block decides when a display source may put its panel into self-refresh and when it must leave it. While the source is armed, it counts frame starts. Once it has seen enough consecutive frames with no dirty plane, it enters self-refresh. Planes that software reports as being rendered are held in a busy mask. The mask is filtered through a relevance mask for the active pipe. Any relevant invalidate or flush forces an immediate exit.

After the last dirty plane is flushed, the block waits a re-arm delay. It then polls a hardware-idle status for a bounded time and re-arms only if no plane became dirty in the meantime. Turning the block off drops the source enable and waits for idle status. A timeout in that wait raises an error flag.

All pins are plain control and status pins. Invalidate and flush are single-cycle strobes that are accepted in every cycle. There is no back-pressure, so a strobe is never stalled or dropped. The delay and timeout are parameters in clock ticks.

Top module: `srefresh_ctrl`

## Requirements
- R1: After reset, sr_enable=0, sr_active=0, busy_mask=0, wait_err=0 and link_on=1. When enable is sampled high while off, sr_enable is 1 after that edge, busy_mask is cleared and wait_err is cleared.
- R2: While armed, the threshold is the larger of 6 and idle_cfg. sr_active rises after the edge that samples the threshold-th frame_start since arming, and not earlier.
- R3: An invalidate ORs (inv_mask AND pipe_mask) into busy_mask. When that masked value is nonzero, sr_enable and sr_active are 0 after the same edge. Planes outside pipe_mask change nothing.
- R4: A flush clears (flush_mask AND pipe_mask) from busy_mask. A nonzero masked flush also forces an exit. When both strobes hit the same plane in one cycle, the invalidate wins and the plane stays busy.
- R5: A flush starts the re-arm delay only when the source is not armed, the updated busy_mask is zero and no re-arm is pending. A flush that leaves planes busy starts nothing.
- R6: The delay lasts DELAY_TICKS cycles. The block then samples hw_idle for up to WAIT_TICKS cycles. With hw_idle high at once, sr_enable rises DELAY_TICKS+1 edges after the flush edge. On timeout, the block gives up and stays unarmed even if hw_idle later rises.
- R7: If a plane is invalidated while a re-arm is pending, the block does not re-arm. The next flush that empties busy_mask schedules a new re-arm.
- R8: link_on is 0 only while sr_active=1 and link_keep=0. Otherwise it is 1.
- R9: sleep_max is the constant 5'h1F.
- R10: enable sampled low drops sr_enable and sr_active after that edge, and the block then waits for hw_idle. If hw_idle stays low for WAIT_TICKS cycles, wait_err is set after the WAIT_TICKS-th edge. wait_err stays set until the next enable.
- R11: While the block is off, invalidate and flush strobes leave busy_mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Feature enable (level) |
| link_keep | input | 1 | 1: keep main link powered in self-refresh |
| idle_cfg | input | CW | Configured idle-frame count |
| pipe_mask | input | NP | Planes that belong to the active pipe |
| frame_start | input | 1 | One-cycle frame start strobe |
| inv_valid | input | 1 | Invalidate strobe |
| inv_mask | input | NP | Planes being dirtied |
| flush_valid | input | 1 | Flush strobe |
| flush_mask | input | NP | Planes flushed |
| hw_idle | input | 1 | Hardware status reports idle |
| sr_enable | output | 1 | Source self-refresh enable (armed) |
| sr_active | output | 1 | Self-refresh entered |
| link_on | output | 1 | Main link powered |
| busy_mask | output | NP | Dirty relevant planes |
| wait_err | output | 1 | Idle wait on disable timed out |
| sleep_max | output | 5 | Maximum sleep time field, fixed 5'h1F |

## Verification
The bench targets the threshold edge at both 6 and a larger configured value. A counter that is off by one would activate one frame early or late. It drives a plane outside the pipe mask, which a design that forgets the mask would treat as dirty and use to exit. It drives a same-cycle invalidate and flush on one plane, where a design with the wrong priority would wrongly clear the plane. It also covers an invalidate during a pending re-arm, which a design that skips the recheck would act on by arming over dirty planes. Finally, it checks both idle-wait timeouts: a design that ignores the timeout would re-arm late or never flag the failed disable.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
  typedef enum logic [2:0] {
    S_OFF     = 3'd0,
    S_ARMED   = 3'd1,
    S_IDLE    = 3'd2,
    S_DELAY   = 3'd3,
    S_HWWAIT  = 3'd4,
    S_DISWAIT = 3'd5
  } srf_state_t;

  localparam logic [4:0] SLEEP_MAX_VAL = 5'h1F;
  localparam int unsigned MIN_IDLE_FRAMES = 6;
endpackage

// File: rtl/srf_dirty_track.sv
`timescale 1ns/1ps
module srf_dirty_track #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic          clr,
  input  logic          inv_valid,
  input  logic [NP-1:0] inv_mask,
  input  logic          flush_valid,
  input  logic [NP-1:0] flush_mask,
  input  logic [NP-1:0] pipe_mask,
  output logic          inv_hit,
  output logic          fl_hit,
  output logic [NP-1:0] busy_next,
  output logic [NP-1:0] busy
);
  logic [NP-1:0] inv_m, fl_m;

  assign inv_m     = inv_valid ? (inv_mask & pipe_mask) : '0;
  assign fl_m      = flush_valid ? (flush_mask & pipe_mask) : '0;
  assign inv_hit   = |inv_m;
  assign fl_hit    = |fl_m;
  // invalidate applied after flush: a plane hit by both stays dirty
  assign busy_next = (busy & ~fl_m) | inv_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy <= '0;
    else if (clr)    busy <= '0;
    else if (upd_en) busy <= busy_next;
  end
endmodule

// File: rtl/srf_idle_count.sv
`timescale 1ns/1ps
module srf_idle_count #(
  parameter int CW       = 4,
  parameter int MIN_IDLE = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          frame,
  input  logic [CW-1:0] cfg,
  output logic          reached
);
  localparam int BW  = (CW > $clog2(MIN_IDLE + 1)) ? CW : $clog2(MIN_IDLE + 1);
  localparam int TCW = BW + 1;
  localparam logic [TCW-1:0] MIN_T = TCW'(MIN_IDLE);

  logic [TCW-1:0] cnt, thr, cfg_w;

  assign cfg_w   = TCW'(cfg);
  assign thr     = (cfg_w > MIN_T) ? cfg_w : MIN_T;
  assign reached = frame && ((cnt + 1'b1) >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (frame && cnt < thr) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srf_tick_timer.sv
`timescale 1ns/1ps
module srf_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srefresh_ctrl.sv
`timescale 1ns/1ps
module srefresh_ctrl
  import srf_pkg::*;
#(
  parameter int NP          = 4,
  parameter int CW          = 4,
  parameter int DELAY_TICKS = 20_000_000,
  parameter int WAIT_TICKS  = 10_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          link_keep,
  input  logic [CW-1:0] idle_cfg,
  input  logic [NP-1:0] pipe_mask,
  input  logic          frame_start,
  input  logic          inv_valid,
  input  logic [NP-1:0] inv_mask,
  input  logic          flush_valid,
  input  logic [NP-1:0] flush_mask,
  input  logic          hw_idle,
  output logic          sr_enable,
  output logic          sr_active,
  output logic          link_on,
  output logic [NP-1:0] busy_mask,
  output logic          wait_err,
  output logic [4:0]    sleep_max
);
  localparam int MAXT = (DELAY_TICKS > WAIT_TICKS) ? DELAY_TICKS : WAIT_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] DLY_LAST  = TW'(DELAY_TICKS - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(WAIT_TICKS - 1);

  srf_state_t    state, nxt;
  logic          inv_hit, fl_hit, dirty, reached, frame_cnt;
  logic          upd_en, busy_clr, tmr_restart;
  logic [NP-1:0] busy_next;
  logic [TW-1:0] tmr;

  assign dirty    = inv_hit | fl_hit;
  assign busy_clr = (state == S_OFF) && enable;
  assign upd_en   = (state != S_OFF) && (state != S_DISWAIT);

  srf_dirty_track #(.NP(NP)) u_dirty (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .clr(busy_clr),
    .inv_valid(inv_valid), .inv_mask(inv_mask),
    .flush_valid(flush_valid), .flush_mask(flush_mask),
    .pipe_mask(pipe_mask), .inv_hit(inv_hit), .fl_hit(fl_hit),
    .busy_next(busy_next), .busy(busy_mask)
  );

  assign frame_cnt = frame_start && (state == S_ARMED) && enable && !sr_active && !dirty;

  srf_idle_count #(.CW(CW), .MIN_IDLE(MIN_IDLE_FRAMES)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(state != S_ARMED || dirty),
    .frame(frame_cnt), .cfg(idle_cfg), .reached(reached)
  );

  assign tmr_restart = (nxt != state);

  srf_tick_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .cnt(tmr)
  );

  always_comb begin
    nxt = state;
    case (state)
      S_OFF:     if (enable) nxt = S_ARMED;
      S_DISWAIT: if (hw_idle || tmr == WAIT_LAST) nxt = S_OFF;
      default: begin
        if (!enable) nxt = S_DISWAIT;
        else begin
          case (state)
            S_ARMED:  if (dirty) nxt = (flush_valid && busy_next == '0) ? S_DELAY : S_IDLE;
            S_IDLE:   if (flush_valid && busy_next == '0) nxt = S_DELAY;
            S_DELAY:  if (tmr == DLY_LAST) nxt = S_HWWAIT;
            S_HWWAIT: begin
              if (hw_idle)                nxt = (busy_next == '0) ? S_ARMED : S_IDLE;
              else if (tmr == WAIT_LAST)  nxt = S_IDLE;
            end
            default:  nxt = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      sr_active <= 1'b0;
      wait_err  <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != S_ARMED || state != S_ARMED) sr_active <= 1'b0;
      else if (reached)                       sr_active <= 1'b1;
      if (busy_clr)
        wait_err <= 1'b0;
      else if (state == S_DISWAIT && !hw_idle && tmr == WAIT_LAST)
        wait_err <= 1'b1;
    end
  end

  assign sr_enable = (state == S_ARMED);
  assign link_on   = !(sr_active && !link_keep);
  assign sleep_max = SLEEP_MAX_VAL;
endmodule

// File: rtl/srf_checker.sv
`timescale 1ns/1ps
module srf_checker #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          frame_start,
  input logic          inv_valid,
  input logic [NP-1:0] inv_mask,
  input logic          flush_valid,
  input logic [NP-1:0] flush_mask,
  input logic [NP-1:0] pipe_mask,
  input logic          hw_idle,
  input logic          sr_enable,
  input logic          sr_active,
  input logic [2:0]    state
);
  // R2: self-refresh only entered as a frame is counted
  p_entry_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_active) |-> $past(frame_start));

  // R2: active implies armed
  p_active_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> sr_enable);

  // R3: relevant invalidate exits
  p_inv_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && |(inv_mask & pipe_mask)) |=> (!sr_active && !sr_enable));

  // R4: relevant flush exits
  p_flush_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && |(flush_mask & pipe_mask)) |=> (!sr_active && !sr_enable));

  // R6: re-arm only after idle status seen (or a fresh enable)
  p_rearm_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_enable) |-> ($past(hw_idle) || $past(state) == 3'd0));

  // R10: disable drops the source enable
  p_disable_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sr_enable);
endmodule

bind srefresh_ctrl srf_checker #(.NP(NP)) u_srf_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
  .inv_valid(inv_valid), .inv_mask(inv_mask), .flush_valid(flush_valid),
  .flush_mask(flush_mask), .pipe_mask(pipe_mask), .hw_idle(hw_idle),
  .sr_enable(sr_enable), .sr_active(sr_active), .state(state)
);

// File: tb/test_srefresh_ctrl.sv
`timescale 1ns/1ps
module test_srefresh_ctrl;
  localparam int NP = 4, CW = 4, D = 20, W = 10;
  localparam int NV = 8;
  // {inv_mask, flush_mask, expected busy}; strobe valid when its mask is nonzero
  localparam logic [11:0] VEC [NV] = '{
    12'b0001_0000_0001, 12'b1000_0000_0001, 12'b0110_0000_0111,
    12'b0000_0010_0101, 12'b0010_0010_0111, 12'b0000_1111_0000,
    12'b0100_0000_0100, 12'b0000_0001_0100
  };

  logic clk = 0, rst_n = 0, enable = 0, link_keep = 0, frame_start = 0;
  logic inv_valid = 0, flush_valid = 0, hw_idle = 0;
  logic [CW-1:0] idle_cfg = 4'd3;
  logic [NP-1:0] pipe_mask = 4'b0111, inv_mask = 0, flush_mask = 0;
  logic sr_enable, sr_active, link_on, wait_err;
  logic [NP-1:0] busy_mask;
  logic [4:0] sleep_max;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  srefresh_ctrl #(.NP(NP), .CW(CW), .DELAY_TICKS(D), .WAIT_TICKS(W)) i_srefresh_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .link_keep(link_keep),
    .idle_cfg(idle_cfg), .pipe_mask(pipe_mask), .frame_start(frame_start),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .flush_valid(flush_valid),
    .flush_mask(flush_mask), .hw_idle(hw_idle), .sr_enable(sr_enable),
    .sr_active(sr_active), .link_on(link_on), .busy_mask(busy_mask),
    .wait_err(wait_err), .sleep_max(sleep_max)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic frame();
    frame_start = 1; step(); frame_start = 0;
  endtask

  task automatic inv(logic [NP-1:0] m);
    inv_valid = 1; inv_mask = m; step(); inv_valid = 0; inv_mask = 0;
  endtask

  task automatic flush(logic [NP-1:0] m);
    flush_valid = 1; flush_mask = m; step(); flush_valid = 0; flush_mask = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; enable = 0; step(); step(); rst_n = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset sr_enable", sr_enable, 0);
    chk("R1 reset sr_active", sr_active, 0);
    chk("R1 reset busy", busy_mask, 0);
    chk("R1 reset wait_err", wait_err, 0);
    chk("R1 reset link_on", link_on, 1);
    chk("R9 sleep_max", sleep_max, 5'h1F);

    enable = 1; step();
    // table of invalidate / flush patterns on the busy mask (R3, R4)
    for (int i = 0; i < NV; i++) begin
      inv_mask    = VEC[i][11:8];  inv_valid   = |VEC[i][11:8];
      flush_mask  = VEC[i][7:4];   flush_valid = |VEC[i][7:4];
      step();
      inv_valid = 0; flush_valid = 0; inv_mask = 0; flush_mask = 0;
      chk("R3/R4 busy table", busy_mask, VEC[i][3:0]);
    end

    // directed
    do_reset();
    idle_cfg = 4'd3; link_keep = 0; hw_idle = 0;
    enable = 1; step();
    chk("R1 armed after enable", sr_enable, 1);
    repeat (5) frame();
    chk("R2 not active before 6 frames", sr_active, 0);
    frame();
    chk("R2 active at 6th frame", sr_active, 1);
    chk("R8 link off when active", link_on, 0);
    link_keep = 1; step();
    chk("R8 link kept with standby", link_on, 1);
    link_keep = 0;

    inv(4'b1000);
    chk("R3 foreign plane no exit", sr_active, 1);
    chk("R3 foreign plane busy", busy_mask, 0);
    inv(4'b0001);
    chk("R3 exit on invalidate", sr_active, 0);
    chk("R3 disarm on invalidate", sr_enable, 0);
    chk("R3 busy set", busy_mask, 4'b0001);

    hw_idle = 1;
    flush(4'b0001);
    chk("R4 flush clears busy", busy_mask, 0);
    repeat (D) step();
    chk("R6 not armed before delay+1", sr_enable, 0);
    step();
    chk("R5 re-armed after delay", sr_enable, 1);

    idle_cfg = 4'd9;
    repeat (8) frame();
    chk("R2 not active before 9 frames", sr_active, 0);
    frame();
    chk("R2 active at cfg 9", sr_active, 1);

    hw_idle = 0;
    flush(4'b0010);
    chk("R4 flush exits", sr_active, 0);
    chk("R4 flush disarms", sr_enable, 0);
    repeat (D + W + 2) step();
    chk("R6 timeout no arm", sr_enable, 0);
    hw_idle = 1;
    repeat (5) step();
    chk("R6 gave up after timeout", sr_enable, 0);

    inv(4'b0011);
    flush(4'b0001);
    chk("R5 partial flush busy", busy_mask, 4'b0010);
    repeat (D + 3) step();
    chk("R5 no re-arm while busy", sr_enable, 0);
    flush(4'b0010);
    repeat (3) step();
    inv(4'b0100);
    repeat (D + 2) step();
    chk("R7 skip when dirtied while pending", sr_enable, 0);
    chk("R7 busy kept", busy_mask, 4'b0100);
    flush(4'b0100);
    repeat (D + 1) step();
    chk("R7 next flush re-arms", sr_enable, 1);

    inv(4'b0010);
    enable = 0; step();
    chk("R10 disable drops enable", sr_enable, 0);
    step();
    chk("R10 no error when idle", wait_err, 0);
    inv(4'b0100);
    chk("R11 invalidate ignored when off", busy_mask, 4'b0010);
    flush(4'b0010);
    chk("R11 flush ignored when off", busy_mask, 4'b0010);
    enable = 1; step();
    chk("R1 enable clears busy", busy_mask, 0);
    chk("R1 enable arms", sr_enable, 1);

    hw_idle = 0;
    enable = 0; step();
    repeat (W - 1) step();
    chk("R10 no error before timeout", wait_err, 0);
    step();
    chk("R10 error on timeout", wait_err, 1);
    enable = 1; step();
    chk("R10 error cleared by enable", wait_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule